// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block encodes and decodes a 64-bit, active-low data path that carries up to four transfers (beats) per clock. On the transmit side, each beat's word is split into four 16-bit lanes. For each lane the block counts how many wires would change level if the true data were driven as-is. It drives the complement whenever that count exceeds half the lane width, which caps switching at 8 wires per lane per transfer. Every beat is compared against the most recent valid beat before it. That includes the last valid beat of the previous clock, so the history carries across clock boundaries. Beats whose valid bit is low leave the history untouched.

Alongside the wires, the encoder drives one active-low inversion flag per lane and one parity bit per lane, computed over the true data. The receive side takes sampled wires, flags and parity, undoes both the inversion and the active-low encoding, and recomputes parity to raise a per-lane error. Beats are numbered 0 to 3 and beat 0 is the earliest transfer of a clock. Both directions hold beat b in bits `[b*64 +: 64]`, with flags and parity in `[b*4 +: 4]`. An asynchronous reset input is released synchronously inside the block.

Top module: `grouped_dbi_codec`

## Requirements
- R1: Lane n of a beat is data bits [16n+15:16n]. Inversion flag bit n and parity bit n of that beat cover lane n only.
- R2: A valid lane is inverted exactly when 9 or more of its 16 wires would otherwise differ from the previous wire level. A count of exactly 8 does not invert.
- R3: The pins are active-low. A non-inverted lane drives ~data with flag_n = 1. An inverted lane drives data with flag_n = 0.
- R4: Beat b is compared against the wires of the latest valid beat before it. That is a lower-numbered valid beat of the same clock, or else the last valid beat of an earlier clock.
- R5: An invalid beat leaves the wire history unchanged. It drives the held wire level, flag_n = 1 on every lane and parity 0.
- R6: Each transmitted parity bit is the XOR of the lane's 16 true data bits, so data plus parity has an even number of ones.
- R7: While reset is active, and right after it, the wire history and every tx wire are all ones, all tx flags are 1, and tx parity, tx_rdy, rx_vld, rx_data and rx_perr are all 0.
- R8: Transmit outputs for a beat appear one clock after its word and valid bit, and tx_rdy[b] repeats that valid bit.
- R9: The receiver restores data = wire_n when flag_n is 0 and ~wire_n when flag_n is 1. Results appear one clock after sampling, with rx_vld[b] = rx_rdy[b].
- R10: rx_perr lane bit is 1 exactly when the XOR of the restored lane differs from the received parity bit.
- R11: For a beat sampled with rx_rdy low, rx_data and rx_perr of that beat keep their previous values and rx_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 4 | Per-beat valid for the transmit words |
| tx_word | input | 256 | Four true data words, beat 0 lowest |
| tx_rdy | output | 4 | Per-beat valid of the driven wires |
| tx_wire_n | output | 256 | Active-low wire levels per beat |
| tx_flag_n | output | 16 | Active-low inversion flag per beat and lane |
| tx_par | output | 16 | Parity per beat and lane |
| rx_rdy | input | 4 | Per-beat valid of sampled wires |
| rx_wire_n | input | 256 | Sampled active-low wire levels |
| rx_flag_n | input | 16 | Sampled active-low inversion flags |
| rx_par | input | 16 | Sampled parity bits |
| rx_vld | output | 4 | Per-beat valid of restored data |
| rx_data | output | 256 | Restored true data |
| rx_perr | output | 16 | Parity error per beat and lane |

## Verification
The toggle threshold is probed at exactly 8 and exactly 9 toggles. A design using "8 or more" would invert the 8-toggle lane, and one counting ones instead of toggles would pick the wrong lanes after any non-idle history. Randomized runs with sparse valid patterns stress the history chain inside a clock and across clocks. A design that let idle beats update the history, or started every clock from the previous clock's beat 3, would drive different wires there. The receiver is fed back the transmitted wires with a single flipped data bit and then a flipped parity bit. A receiver that restored the wrong polarity, raised errors on the wrong lane, or failed to hold values across idle beats would show mismatched data or error bits.

// File: rtl/dbi_pkg.sv
`timescale 1ns/1ps
package dbi_pkg;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_LANE_W = 16;
  localparam int unsigned DEF_BEATS  = 4;

  // Inversion pays off only when more than half the wires would move.
  function automatic logic exceeds_half(input int unsigned toggles, input int unsigned width);
    return toggles > (width / 2);
  endfunction
endpackage

// File: rtl/dbi_lane_enc.sv
`timescale 1ns/1ps
module dbi_lane_enc #(
  parameter int unsigned LANE_W = dbi_pkg::DEF_LANE_W
) (
  input  logic [LANE_W-1:0] prev_wire,
  input  logic [LANE_W-1:0] data,
  output logic [LANE_W-1:0] wire_n,
  output logic              inv,
  output logic              par
);
  logic [LANE_W-1:0] plain_level;

  // Active-low pins: an uninverted lane carries the complement of the data.
  assign plain_level = ~data;
  assign inv    = dbi_pkg::exceeds_half($countones(plain_level ^ prev_wire), LANE_W);
  assign wire_n = inv ? data : plain_level;
  assign par    = ^data;
endmodule

// File: rtl/dbi_lane_dec.sv
`timescale 1ns/1ps
module dbi_lane_dec #(
  parameter int unsigned LANE_W = dbi_pkg::DEF_LANE_W
) (
  input  logic [LANE_W-1:0] wire_n,
  input  logic              flag_n,
  input  logic              par,
  output logic [LANE_W-1:0] data,
  output logic              err
);
  assign data = flag_n ? ~wire_n : wire_n;
  assign err  = (^data) ^ par;
endmodule

// File: rtl/dbi_tx.sv
`timescale 1ns/1ps
module dbi_tx #(
  parameter int unsigned DATA_W = dbi_pkg::DEF_DATA_W,
  parameter int unsigned LANE_W = dbi_pkg::DEF_LANE_W,
  parameter int unsigned BEATS  = dbi_pkg::DEF_BEATS,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BEATS-1:0]        in_valid,
  input  logic [BEATS*DATA_W-1:0] in_word,
  output logic [BEATS-1:0]        out_rdy,
  output logic [BEATS*DATA_W-1:0] out_wire_n,
  output logic [BEATS*LANES-1:0]  out_flag_n,
  output logic [BEATS*LANES-1:0]  out_par
);
  logic [DATA_W-1:0] hist_q, hist_d;
  logic              hist_en;
  logic [DATA_W-1:0] chain    [BEATS+1];
  logic [DATA_W-1:0] enc_wire [BEATS];
  logic [LANES-1:0]  enc_inv  [BEATS];
  logic [LANES-1:0]  enc_par  [BEATS];

  logic [BEATS*DATA_W-1:0] wire_d;
  logic [BEATS*LANES-1:0]  flag_d;
  logic [BEATS*LANES-1:0]  par_d;

  assign chain[0] = hist_q;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
        .prev_wire (chain[b][l*LANE_W +: LANE_W]),
        .data      (in_word[b*DATA_W + l*LANE_W +: LANE_W]),
        .wire_n    (enc_wire[b][l*LANE_W +: LANE_W]),
        .inv       (enc_inv[b][l]),
        .par       (enc_par[b][l])
      );

      assert_toggle_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[b] |-> ($countones(enc_wire[b][l*LANE_W +: LANE_W] ^ chain[b][l*LANE_W +: LANE_W]) <= LANE_W/2));

      assert_restorable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[b] |-> ((enc_inv[b][l] ? enc_wire[b][l*LANE_W +: LANE_W] : ~enc_wire[b][l*LANE_W +: LANE_W])
                         == in_word[b*DATA_W + l*LANE_W +: LANE_W]));

      assert_even_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[b] |-> !(^{in_word[b*DATA_W + l*LANE_W +: LANE_W], enc_par[b][l]}));
    end

    // An idle beat passes the held level straight through to the next beat.
    assign chain[b+1] = in_valid[b] ? enc_wire[b] : chain[b];

    assert_rdy_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[b] |=> out_rdy[b]);

    assert_idle_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_rdy[b] |-> ((&out_flag_n[b*LANES +: LANES]) && (out_par[b*LANES +: LANES] == '0)));
  end

  always_comb begin
    hist_en = |in_valid;
    hist_d  = chain[BEATS];
    for (int b = 0; b < BEATS; b++) begin
      wire_d[b*DATA_W +: DATA_W] = chain[b+1];
      flag_d[b*LANES +: LANES]   = in_valid[b] ? ~enc_inv[b] : '1;
      par_d[b*LANES +: LANES]    = in_valid[b] ? enc_par[b]  : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q     <= '1;
      out_wire_n <= '1;
      out_flag_n <= '1;
      out_par    <= '0;
      out_rdy    <= '0;
    end else begin
      if (hist_en) hist_q <= hist_d;
      out_wire_n <= wire_d;
      out_flag_n <= flag_d;
      out_par    <= par_d;
      out_rdy    <= in_valid;
    end
  end

  assert_history_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_valid) |=> $stable(hist_q));
endmodule

// File: rtl/dbi_rx.sv
`timescale 1ns/1ps
module dbi_rx #(
  parameter int unsigned DATA_W = dbi_pkg::DEF_DATA_W,
  parameter int unsigned LANE_W = dbi_pkg::DEF_LANE_W,
  parameter int unsigned BEATS  = dbi_pkg::DEF_BEATS,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BEATS-1:0]        in_rdy,
  input  logic [BEATS*DATA_W-1:0] in_wire_n,
  input  logic [BEATS*LANES-1:0]  in_flag_n,
  input  logic [BEATS*LANES-1:0]  in_par,
  output logic [BEATS-1:0]        out_vld,
  output logic [BEATS*DATA_W-1:0] out_data,
  output logic [BEATS*LANES-1:0]  out_err
);
  logic [BEATS*DATA_W-1:0] data_d;
  logic [BEATS*LANES-1:0]  err_d;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
        .wire_n (in_wire_n[b*DATA_W + l*LANE_W +: LANE_W]),
        .flag_n (in_flag_n[b*LANES + l]),
        .par    (in_par[b*LANES + l]),
        .data   (data_d[b*DATA_W + l*LANE_W +: LANE_W]),
        .err    (err_d[b*LANES + l])
      );
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_data[b*DATA_W +: DATA_W] <= '0;
        out_err[b*LANES +: LANES]    <= '0;
      end else if (in_rdy[b]) begin
        out_data[b*DATA_W +: DATA_W] <= data_d[b*DATA_W +: DATA_W];
        out_err[b*LANES +: LANES]    <= err_d[b*LANES +: LANES];
      end
    end

    assert_vld_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_rdy[b] |=> out_vld[b]);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_rdy[b] |=> ($stable(out_data[b*DATA_W +: DATA_W]) && $stable(out_err[b*LANES +: LANES])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= '0;
    else        out_vld <= in_rdy;
  end
endmodule

// File: rtl/grouped_dbi_codec.sv
`timescale 1ns/1ps
module grouped_dbi_codec #(
  parameter int unsigned DATA_W = dbi_pkg::DEF_DATA_W,
  parameter int unsigned LANE_W = dbi_pkg::DEF_LANE_W,
  parameter int unsigned BEATS  = dbi_pkg::DEF_BEATS,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BEATS-1:0]        tx_valid,
  input  logic [BEATS*DATA_W-1:0] tx_word,
  output logic [BEATS-1:0]        tx_rdy,
  output logic [BEATS*DATA_W-1:0] tx_wire_n,
  output logic [BEATS*LANES-1:0]  tx_flag_n,
  output logic [BEATS*LANES-1:0]  tx_par,
  input  logic [BEATS-1:0]        rx_rdy,
  input  logic [BEATS*DATA_W-1:0] rx_wire_n,
  input  logic [BEATS*LANES-1:0]  rx_flag_n,
  input  logic [BEATS*LANES-1:0]  rx_par,
  output logic [BEATS-1:0]        rx_vld,
  output logic [BEATS*DATA_W-1:0] rx_data,
  output logic [BEATS*LANES-1:0]  rx_perr
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  dbi_tx #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BEATS(BEATS)) u_tx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .in_valid   (tx_valid),
    .in_word    (tx_word),
    .out_rdy    (tx_rdy),
    .out_wire_n (tx_wire_n),
    .out_flag_n (tx_flag_n),
    .out_par    (tx_par)
  );

  dbi_rx #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BEATS(BEATS)) u_rx (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .in_rdy    (rx_rdy),
    .in_wire_n (rx_wire_n),
    .in_flag_n (rx_flag_n),
    .in_par    (rx_par),
    .out_vld   (rx_vld),
    .out_data  (rx_data),
    .out_err   (rx_perr)
  );
endmodule

// File: tb/tb_grouped_dbi_codec.sv
`timescale 1ns/1ps
module tb_grouped_dbi_codec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   tx_valid = '0;
  logic [255:0] tx_word = '0;
  logic [3:0]   tx_rdy;
  logic [255:0] tx_wire_n;
  logic [15:0]  tx_flag_n, tx_par;
  logic [3:0]   rx_vld;
  logic [255:0] rx_data;
  logic [15:0]  rx_perr;
  logic [255:0] wmask = '0;
  logic [15:0]  pmask = '0;

  always #2.5 clk = ~clk;

  grouped_dbi_codec dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_word(tx_word),
    .tx_rdy(tx_rdy), .tx_wire_n(tx_wire_n), .tx_flag_n(tx_flag_n), .tx_par(tx_par),
    .rx_rdy(tx_rdy), .rx_wire_n(tx_wire_n ^ wmask), .rx_flag_n(tx_flag_n), .rx_par(tx_par ^ pmask),
    .rx_vld(rx_vld), .rx_data(rx_data), .rx_perr(rx_perr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Hand-worked beat-0 vectors starting from the reset history (all ones).
  localparam logic [63:0] VEC_D [4] = '{64'h0, 64'h0000_FFFF_01FF_00FF, 64'h0, 64'h0000_0000_0000_01FF};
  localparam logic [63:0] VEC_W [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_01FF_FF00,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_01FF};
  localparam logic [3:0]  VEC_F [4] = '{4'hF, 4'h9, 4'hF, 4'hE};
  localparam logic [3:0]  VEC_P [4] = '{4'h0, 4'h2, 4'h0, 4'h1};

  logic [63:0]  m_hist;
  logic [3:0]   prev_v;
  logic [255:0] prev_w;
  logic [255:0] rx_last;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist = '1; prev_v = '0; prev_w = '0; rx_last = '0;
  endtask

  task automatic model(input logic [3:0] v, input logic [255:0] w,
                       output logic [255:0] ew, output logic [15:0] ef, output logic [15:0] ep);
    for (int b = 0; b < 4; b++) begin
      for (int l = 0; l < 4; l++) begin
        logic [15:0] d, h, cand, wl;
        logic inv;
        d = w[b*64 + l*16 +: 16];
        h = m_hist[l*16 +: 16];
        if (v[b]) begin
          cand = ~d;
          inv = $countones(cand ^ h) > 8;
          wl = inv ? d : cand;
          m_hist[l*16 +: 16] = wl;
          ef[b*4 + l] = ~inv;
          ep[b*4 + l] = ^d;
        end else begin
          wl = h;
          ef[b*4 + l] = 1'b1;
          ep[b*4 + l] = 1'b0;
        end
        ew[b*64 + l*16 +: 16] = wl;
      end
    end
  endtask

  // Drive one clock of beats, then check tx (this cycle) and rx (last cycle).
  task automatic cycle(input logic [3:0] v, input logic [255:0] w);
    logic [255:0] ew;
    logic [15:0] ef, ep;
    model(v, w, ew, ef, ep);
    tx_valid = v;
    tx_word = w;
    @(negedge clk);
    chk("R8 tx_rdy", {252'd0, tx_rdy}, {252'd0, v});
    chk("R4 tx_wire_n", tx_wire_n, ew);
    chk("R2 tx_flag_n", {240'd0, tx_flag_n}, {240'd0, ef});
    chk("R6 tx_par", {240'd0, tx_par}, {240'd0, ep});
    for (int b = 0; b < 4; b++)
      if (prev_v[b]) rx_last[b*64 +: 64] = prev_w[b*64 +: 64];
    chk("R9 rx_vld", {252'd0, rx_vld}, {252'd0, prev_v});
    chk("R11 rx_data", rx_data, rx_last);
    chk("R10 rx_perr", {240'd0, rx_perr}, 256'd0);
    prev_v = v;
    prev_w = w;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " tx_wire_n"}, tx_wire_n, {256{1'b1}});
    chk({tag, " tx_flag_n"}, {240'd0, tx_flag_n}, {240'd0, 16'hFFFF});
    chk({tag, " tx_par"}, {240'd0, tx_par}, 256'd0);
    chk({tag, " tx_rdy"}, {252'd0, tx_rdy}, 256'd0);
    chk({tag, " rx_vld"}, {252'd0, rx_vld}, 256'd0);
    chk({tag, " rx_data"}, rx_data, 256'd0);
    chk({tag, " rx_perr"}, {240'd0, rx_perr}, 256'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state("R7 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R7 after release");

    // Table walk: 8-vs-9 toggle boundary, lane mapping (R1), pin polarity (R3).
    for (int i = 0; i < 4; i++) begin
      cycle(4'b0001, {192'd0, VEC_D[i]});
      chk("R1 R2 table wire", {192'd0, tx_wire_n[63:0]}, {192'd0, VEC_W[i]});
      chk("R3 table flag_n", {252'd0, tx_flag_n[3:0]}, {252'd0, VEC_F[i]});
      chk("R6 table par", {252'd0, tx_par[3:0]}, {252'd0, VEC_P[i]});
    end

    // R4: beat 3 of one clock feeds beat 0 of the next; beat 1 skips idle beat 0.
    cycle(4'b1000, {64'h0000_0000_0000_FFFF, 192'd0});
    cycle(4'b0001, {192'd0, 64'h0000_0000_0000_0000});
    cycle(4'b0010, {128'd0, 64'h0000_0000_00FF_01FF, 64'h0});
    cycle(4'b0000, 256'd0);

    // R5 R4: random words with sparse valid patterns.
    for (int i = 0; i < 300; i++) begin
      logic [255:0] w;
      w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      cycle(4'($urandom), w);
    end
    cycle(4'b0000, 256'd0);

    // R7: reset in mid-run restores the idle history.
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R7 mid reset");
    rst_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    cycle(4'b0001, {192'd0, 64'h0000_0000_0000_01FF});
    chk("R2 after reset flag_n", {252'd0, tx_flag_n[3:0]}, {252'd0, 4'hE});
    cycle(4'b0000, 256'd0);

    // R10 R9: flipped data wire in lane 2 of beat 0.
    wmask = 256'd1 << 35;
    tx_valid = 4'b0001;
    tx_word = {192'd0, 64'h1234_5678_9ABC_DEF0};
    @(negedge clk);
    tx_valid = 4'b0000;
    @(negedge clk);
    chk("R9 corrupted data", {192'd0, rx_data[63:0]}, {192'd0, 64'h1234_5678_9ABC_DEF0 ^ (64'd1 << 35)});
    chk("R10 lane2 error", {252'd0, rx_perr[3:0]}, {252'd0, 4'b0100});
    wmask = '0;

    // R10: flipped parity bit of lane 1.
    pmask = 16'h0002;
    tx_valid = 4'b0001;
    tx_word = {192'd0, 64'h0F0F_0000_FFFF_0001};
    @(negedge clk);
    tx_valid = 4'b0000;
    @(negedge clk);
    chk("R9 clean data", {192'd0, rx_data[63:0]}, {192'd0, 64'h0F0F_0000_FFFF_0001});
    chk("R10 lane1 error", {252'd0, rx_perr[3:0]}, {252'd0, 4'b0010});
    pmask = '0;

    // R11: idle sample keeps restored data and errors.
    @(negedge clk);
    chk("R11 idle vld", {252'd0, rx_vld}, 256'd0);
    chk("R11 idle data", {192'd0, rx_data[63:0]}, {192'd0, 64'h0F0F_0000_FFFF_0001});
    chk("R11 idle err", {252'd0, rx_perr[3:0]}, {252'd0, 4'b0010});

    finish_run();
  end
endmodule